// File: doc/BRIEF.md
# Windowed Integer Multiply-Accumulate Unit

This unit is a pipelined 32x32 integer multiplier meant as a building block for software floating-point and multi-word arithmetic. Every operation forms the full 64-bit product of its two operands and returns one 32-bit slice of it. The slice is chosen by a right-shift amount, so the low half, the high half or any window in between can be read out. An optional 32-bit addend is summed into the chosen slice, and a carry flag reports the bit lost when that sum wraps. Software can therefore chain partial products into wider results.

A reduced mode multiplies only the low 16 bits of each operand and returns the whole 32-bit product. Operations enter with a valid strobe and a caller-chosen tag. One operation can enter every cycle, and each leaves exactly three cycles later with its tag.

Four operations are enough to build the low 64 bits of a 64x64 product: low and high slices of the low-by-low product, then two accumulating low-slice products of the cross terms.

Top module: `win_mac`

## Requirements
- R1: While `rst` is high at a clock edge, all pipeline stages are emptied. `out_valid` stays low during reset and for the first three cycles after reset is released, whatever `in_valid` was doing during reset.
- R2: An operation accepted with `in_valid` high produces `out_valid` high exactly three clock edges later, carrying the same `tag_in` on `tag_out`. A new operation can be accepted on every cycle, and `out_valid` is never high without a matching accepted operation.
- R3: With `narrow` low, a shift of 0 returns product bits 31:0 and a shift of 32 returns product bits 63:32.
- R4: With `narrow` low, a shift k from 1 to 31 returns product bits k+31:k. Any shift above 32 behaves as 32.
- R5: With `narrow` low, `signed_en` high treats both operands as two's complement. `signed_en` low treats them as unsigned.
- R6: With `acc_en` high, `result` is the selected slice plus `acc_in`, modulo 2^32, and `carry_out` is bit 32 of that sum. With `acc_en` low, `acc_in` has no effect and `carry_out` is 0.
- R7: With `narrow` high, `result` is the unsigned product of bits 15:0 of each operand. Bits 31:16 of the operands, `shamt` and `signed_en` are ignored, and `acc_en` still applies as in R6.
- R8: For unsigned 64-bit A and B, four operations give the low 64 bits of A*B. The operations are: lo(Al*Bl) with shift 0; hi(Al*Bl) with shift 32; Al*Bh with shift 0, accumulating the previous result; Ah*Bl with shift 0, accumulating the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| acc_in | input | 32 | Addend for accumulate |
| shamt | input | 6 | Right shift selecting the product slice (0..32, larger clamps) |
| signed_en | input | 1 | 1: two's-complement operands, 0: unsigned |
| acc_en | input | 1 | 1: add `acc_in` to the slice |
| narrow | input | 1 | 1: 16x16 mode |
| tag_in | input | TAG_W (4) | Caller tag carried with the operation |
| out_valid | output | 1 | Result present |
| result | output | 32 | Selected slice, optionally accumulated |
| carry_out | output | 1 | Carry out of the accumulate sum |
| tag_out | output | TAG_W (4) | Tag of the operation in `result` |

## Verification
Two functions can act in one cycle: the shifted slice selection and the accumulate carry. This happens when a mid-range window such as shift 7 is summed with an addend large enough to wrap. The bench drives these cases and compares both `result` and `carry_out` against a 64-bit reference model. Two more functions overlap when a 16x16 operation is issued on the cycle right after a signed wide operation with a large shift, so both share the pipeline at once. The scoreboard checks that neither operation's shift, signedness or addend leaks into the other's result.

// File: rtl/win_mac.sv
module win_mac #(
  parameter int W = 32,
  parameter int TAG_W = 4,
  localparam int SH_W = $clog2(2 * W),
  localparam int NW = W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [W-1:0]     acc_in,
  input  logic [SH_W-1:0]  shamt,
  input  logic             signed_en,
  input  logic             acc_en,
  input  logic             narrow,
  input  logic [TAG_W-1:0] tag_in,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             carry_out,
  output logic [TAG_W-1:0] tag_out
);

  logic             s1_v, s2_v;
  logic [W-1:0]     s1_a, s1_b, s1_acc, s2_acc;
  logic [SH_W-1:0]  s1_sh, s2_sh;
  logic             s1_sg, s1_ae, s1_nr, s2_ae;
  logic [TAG_W-1:0] s1_tag, s2_tag;
  logic [2*W-1:0]   s2_p;

  logic signed [2*W+1:0] wide_p;
  logic [W-1:0]          nar_p;
  logic [W-1:0]          win;
  logic [W:0]            sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_a   <= op_a;
    s1_b   <= op_b;
    s1_acc <= acc_in;
    s1_sh  <= narrow ? '0 : (shamt > SH_W'(W) ? SH_W'(W) : shamt);
    s1_sg  <= signed_en;
    s1_ae  <= acc_en;
    s1_nr  <= narrow;
    s1_tag <= tag_in;
  end

  assign wide_p = $signed({s1_sg & s1_a[W-1], s1_a}) * $signed({s1_sg & s1_b[W-1], s1_b});
  assign nar_p  = W'(s1_a[NW-1:0]) * W'(s1_b[NW-1:0]);

  always_ff @(posedge clk) begin
    s2_p   <= s1_nr ? {{W{1'b0}}, nar_p} : wide_p[2*W-1:0];
    s2_sh  <= s1_sh;
    s2_acc <= s1_acc;
    s2_ae  <= s1_ae;
    s2_tag <= s1_tag;
  end

  assign win = W'(s2_p >> s2_sh);
  assign sum = {1'b0, win} + {1'b0, (s2_ae ? s2_acc : {W{1'b0}})};

  always_ff @(posedge clk) begin
    result    <= sum[W-1:0];
    carry_out <= sum[W];
    tag_out   <= s2_tag;
  end

endmodule

module win_mac_chk #(
  parameter int W = 32,
  parameter int TAG_W = 4,
  localparam int SH_W = $clog2(2 * W),
  localparam int NW = W / 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [W-1:0]     op_a,
  input logic [W-1:0]     op_b,
  input logic [W-1:0]     acc_in,
  input logic [SH_W-1:0]  shamt,
  input logic             signed_en,
  input logic             acc_en,
  input logic             narrow,
  input logic [TAG_W-1:0] tag_in,
  input logic             out_valid,
  input logic [W-1:0]     result,
  input logic             carry_out,
  input logic [TAG_W-1:0] tag_out
);

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd3) |-> !out_valid);

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) && !$past(in_valid, 3) |-> !out_valid);

  a_r2_tag_follows: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) && out_valid |-> tag_out == $past(tag_in, 3));

  a_r6_no_carry_plain: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) && out_valid && !$past(acc_en, 3) |-> !carry_out);

  a_r7_narrow_product: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) && out_valid && $past(narrow, 3) && !$past(acc_en, 3)
      |-> result == $past(W'(op_a[NW-1:0]) * W'(op_b[NW-1:0]), 3));

endmodule

bind win_mac win_mac_chk #(.W(W), .TAG_W(TAG_W)) chk_i (.*);

// File: tb/win_mac_tb_top.sv
module win_mac_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc_in = '0;
  logic [5:0]  shamt = '0;
  logic        signed_en = 1'b0, acc_en = 1'b0, narrow = 1'b0;
  logic [3:0]  tag_in = '0;
  logic        out_valid, carry_out;
  logic [31:0] result;
  logic [3:0]  tag_out;

  int errors = 0;
  int checks = 0;
  int issued = 0;
  int seen = 0;
  logic [3:0]  tag_ctr = '0;
  logic [31:0] last_res = '0;

  logic [31:0] q_res[$];
  logic        q_c[$];
  logic [3:0]  q_tag[$];
  string       q_req[$];

  always #5 clk = ~clk;

  win_mac dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] acc, input int sh, input bit sg, input bit ae, input bit nr);
    logic [63:0] p;
    logic [31:0] w;
    int s;
    if (nr) begin
      p = 64'(a[15:0]) * 64'(b[15:0]);
      s = 0;
    end else begin
      if (sg) p = 64'(longint'($signed(a)) * longint'($signed(b)));
      else    p = 64'(a) * 64'(b);
      s = (sh > 32) ? 32 : sh;
    end
    w = 32'(p >> s);
    return {1'b0, w} + (ae ? {1'b0, acc} : 33'd0);
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc,
      input int sh, input bit sg, input bit ae, input bit nr, input string req);
    logic [32:0] e;
    e = model(a, b, acc, sh, sg, ae, nr);
    in_valid = 1'b1; op_a = a; op_b = b; acc_in = acc; shamt = 6'(sh);
    signed_en = sg; acc_en = ae; narrow = nr; tag_in = tag_ctr;
    q_res.push_back(e[31:0]); q_c.push_back(e[32]); q_tag.push_back(tag_ctr); q_req.push_back(req);
    tag_ctr = tag_ctr + 4'd1;
    issued++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      seen++;
      last_res = result;
      if (q_res.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", 64'(result), 64'(0));
      end else begin
        logic [31:0] er; logic ec; logic [3:0] et; string rq;
        er = q_res.pop_front(); ec = q_c.pop_front(); et = q_tag.pop_front(); rq = q_req.pop_front();
        check(result == er, {rq, " result"}, 64'(result), 64'(er));
        check(carry_out == ec, {rq, " carry"}, 64'(carry_out), 64'(ec));
        check(tag_out == et, "R2 tag", 64'(tag_out), 64'(et));
      end
    end
  end

  task automatic compose(input logic [63:0] A, input logic [63:0] B);
    logic [31:0] lo, hi, t;
    logic [127:0] ref128;
    issue(A[31:0], B[31:0], 0, 0, 0, 0, 0, "R8 step1"); idle(3); lo = last_res;
    issue(A[31:0], B[31:0], 0, 32, 0, 0, 0, "R8 step2"); idle(3); t = last_res;
    issue(A[31:0], B[63:32], t, 0, 0, 1, 0, "R8 step3"); idle(3); t = last_res;
    issue(A[63:32], B[31:0], t, 0, 0, 1, 0, "R8 step4"); idle(3); hi = last_res;
    ref128 = 128'(A) * 128'(B);
    check({hi, lo} == ref128[63:0], "R8 composed 64x64", {hi, lo}, ref128[63:0]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'(0));
      @(negedge clk);
    end

    issue(32'h89AB_CDEF, 32'h1234_5678, 0, 0, 0, 0, 0, "R3 low half");
    issue(32'h89AB_CDEF, 32'h1234_5678, 0, 32, 0, 0, 0, "R3 high half");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 32, 0, 0, 0, "R3 high max");
    issue(32'h89AB_CDEF, 32'h1234_5678, 0, 7, 0, 0, 0, "R4 shift 7");
    issue(32'hDEAD_BEEF, 32'hCAFE_F00D, 0, 31, 0, 0, 0, "R4 shift 31");
    issue(32'hDEAD_BEEF, 32'hCAFE_F00D, 0, 45, 0, 0, 0, "R4 clamp 45");
    issue(32'hFFFF_FFFD, 32'h0000_0005, 0, 32, 1, 0, 0, "R5 signed high");
    issue(32'hFFFF_FFFD, 32'h0000_0005, 0, 32, 0, 0, 0, "R5 unsigned high");
    issue(32'h8000_0000, 32'h8000_0000, 0, 16, 1, 0, 0, "R5 signed min");
    issue(32'h89AB_CDEF, 32'h1234_5678, 32'hF000_0000, 7, 0, 1, 0, "R6 accumulate wrap");
    issue(32'h0000_0003, 32'h0000_0004, 32'h0000_0010, 0, 0, 1, 0, "R6 accumulate small");
    issue(32'h0000_0003, 32'h0000_0004, 32'hFFFF_FFFF, 0, 0, 0, 0, "R6 addend ignored");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 40, 1, 0, 0, "R5 signed wide before narrow");
    issue(32'hA5A5_FFFF, 32'h5A5A_FFFF, 0, 20, 1, 0, 1, "R7 narrow ignores upper");
    issue(32'h0000_1234, 32'h0000_8001, 32'hFFFF_FFF0, 9, 0, 1, 1, "R7 narrow accumulate");
    idle(5);

    for (int i = 0; i < 20; i++)
      issue(32'h1357_9BDF * (i + 1), 32'h0246_8ACE ^ (i * 32'h0101_0101), i * 32'h0F0F_0F0F,
            (i * 5) % 40, i[0], i[1], (i % 5 == 4), "R2 back-to-back");
    idle(6);

    compose(64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF);
    compose(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(4);

    check(seen == issued, "R2 result count", 64'(seen), 64'(issued));
    check(q_res.size() == 0, "R2 scoreboard drained", 64'(q_res.size()), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule